// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block fronts a small shared word memory used by several agents. Besides plain reads and writes, it adds a linked load and a conditional store. A linked load returns a word and records in that agent's single reservation slot that it holds the word's address. A conditional store writes only if that reservation is still intact, and it reports success or failure. Software builds locks, counters and other atomic updates from this pair. No agent ever holds the memory across the two operations. Atomicity comes from detecting an intervening write from any agent.

Requests from all agents compete in a fixed-priority arbiter. One request is served per cycle. The winner sees a combinational grant and its request takes effect at the next clock edge. The response comes back one cycle later on a shared response bus, tagged with a one-hot valid. An agent holds its request until it sees its grant.

Top module: `llsc_monitor`

## Requirements
- R1: In each cycle, at most one grant bit is set. It goes, in the same cycle, to the lowest-indexed agent whose request is valid.
- R2: One cycle after a grant, `rsp_valid` is one-hot for the granted agent. `rsp_rdata` carries the word at the requested address as it was before that request's own write. With no grant, `rsp_valid` is zero.
- R3: Operation codes are 0 = read, 1 = write, 2 = linked load and 3 = conditional store. A read and a write both return `rsp_ok` = 1. A write stores `wdata` at the address.
- R4: A linked load returns the word and sets the issuing agent's reservation to that address. This replaces any reservation the agent held before.
- R5: A conditional store succeeds when the issuer holds a valid reservation for the same address. It then writes `wdata` and returns `rsp_ok` = 1.
- R6: A conditional store fails when the issuer has no reservation or holds one for another address. It leaves memory unchanged and returns `rsp_ok` = 0.
- R7: Every committed write clears the reservation of every agent linked to that address. This covers both plain writes and successful conditional stores.
- R8: A conditional store always clears the issuer's own reservation, whether it succeeds or fails.
- R9: Reset clears all memory words to zero, drops every reservation and deasserts `rsp_valid`.
- R10: Two agents may present conditional stores to one linked address in the same cycle. The arbiter winner succeeds, and the other agent's store then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_AGENTS | Per-agent request valid |
| req_op | input | 2*N_AGENTS | Per-agent operation code, agent i at bits [2i+1:2i] |
| req_addr | input | ADDR_W*N_AGENTS | Per-agent word address |
| req_wdata | input | DATA_W*N_AGENTS | Per-agent store data |
| grant | output | N_AGENTS | Combinational one-hot grant |
| rsp_valid | output | N_AGENTS | One-hot response valid, one cycle after grant |
| rsp_rdata | output | DATA_W | Word read by the served request |
| rsp_ok | output | 1 | Success flag; 0 only for a failed conditional store |

## Verification
The bench uses the default parameters: four agents and a sixteen-word memory of 32-bit words. Random traffic is confined to four addresses. As a result, links, intervening writes from other agents and same-cycle conditional stores to one address happen often. Four agents make priority chains three deep, so a low-priority agent's link can be broken by any of several winners before its store is served.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } llsc_op_e;

    localparam int OP_W = 2;

    function automatic logic op_returns_ok(input llsc_op_e op, input logic link_hit);
        return (op == OP_COND) ? link_hit : 1'b1;
    endfunction

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_AGENTS-1:0] req,
    output logic [N_AGENTS-1:0] gnt,
    output logic [IDX_W-1:0]    gnt_idx,
    output logic                any_gnt
);
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any_gnt = 1'b0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_idx = IDX_W'(i);
                any_gnt = 1'b1;
            end
        end
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_grant_requested_R1: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    assert_grant_if_any_R1: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ADDR_W   = 4,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  llsc_op_e          op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_commit,
    output logic              link_hit
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_q [N_AGENTS];

    always_comb begin
        link_hit = 1'b0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (IDX_W'(i) == idx && resv_q[i].valid && resv_q[i].addr == addr)
                link_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_AGENTS; i++) resv_q[i] <= '0;
        end else if (fire) begin
            for (int i = 0; i < N_AGENTS; i++) begin
                if (wr_commit && resv_q[i].valid && resv_q[i].addr == addr)
                    resv_q[i].valid <= 1'b0;
                if (IDX_W'(i) == idx) begin
                    if (op == OP_LINK)
                        resv_q[i] <= '{valid: 1'b1, addr: addr};
                    else if (op == OP_COND)
                        resv_q[i].valid <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_chk
        assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
            (fire && wr_commit) |=> !(resv_q[g].valid && resv_q[g].addr == $past(addr)));
        assert_link_sets_R4: assert property (@(posedge clk) disable iff (rst)
            (fire && op == OP_LINK && idx == IDX_W'(g))
            |=> (resv_q[g].valid && resv_q[g].addr == $past(addr)));
        assert_cond_drops_own_R8: assert property (@(posedge clk) disable iff (rst)
            (fire && op == OP_COND && idx == IDX_W'(g)) |=> !resv_q[g].valid);
    end

endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_AGENTS-1:0]        req_valid,
    input  logic [OP_W*N_AGENTS-1:0]   req_op,
    input  logic [ADDR_W*N_AGENTS-1:0] req_addr,
    input  logic [DATA_W*N_AGENTS-1:0] req_wdata,
    output logic [N_AGENTS-1:0]        grant,
    output logic [N_AGENTS-1:0]        rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       rsp_ok
);
    logic [IDX_W-1:0]  sel_idx;
    logic              fire;
    llsc_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              link_hit;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    llsc_arbiter #(.N_AGENTS(N_AGENTS)) u_arb (
        .clk(clk), .rst(rst), .req(req_valid),
        .gnt(grant), .gnt_idx(sel_idx), .any_gnt(fire)
    );

    always_comb begin
        sel_op    = OP_READ;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (IDX_W'(i) == sel_idx) begin
                sel_op    = llsc_op_e'(req_op[i*OP_W +: OP_W]);
                sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
                sel_wdata = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    assign mem_we = fire && (sel_op == OP_WRITE || (sel_op == OP_COND && link_hit));

    llsc_resv_table #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_resv (
        .clk(clk), .rst(rst), .fire(fire), .op(sel_op), .idx(sel_idx),
        .addr(sel_addr), .wr_commit(mem_we), .link_hit(link_hit)
    );

    llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .addr(sel_addr),
        .wdata(sel_wdata), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= grant;
            if (fire) begin
                rsp_rdata <= mem_rdata;
                rsp_ok    <= op_returns_ok(sel_op, link_hit);
            end
        end
    end

    assert_rsp_follows_grant_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(grant)));
    assert_plain_ok_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op != OP_COND) |=> rsp_ok);
    assert_failed_cond_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op == OP_COND) |=> (rsp_ok == $past(mem_we)));

endmodule

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req_valid = '0;
    logic [2*N-1:0]    req_op = '0;
    logic [AW*N-1:0]   req_addr = '0;
    logic [DW*N-1:0]   req_wdata = '0;
    logic [N-1:0]      grant;
    logic [N-1:0]      rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_ok;

    always #2.5 clk = ~clk;

    llsc_monitor #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
    );

    // reference model state
    logic [DW-1:0] m_mem [16];
    bit            m_rv [N];
    logic [AW-1:0] m_ra [N];
    logic [N-1:0]  e_valid;
    logic [DW-1:0] e_rdata;
    logic          e_ok;
    string         e_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin
            m_rv[i] = 0;
            m_ra[i] = '0;
        end
        e_valid = '0;
        e_rdata = '0;
        e_ok    = 1'b0;
        e_tag   = "R9";
    endtask

    task automatic check_rsp();
        check("R2 rsp_valid", 64'(rsp_valid), 64'(e_valid));
        if (e_valid != 0) begin
            check({e_tag, " rsp_rdata"}, 64'(rsp_rdata), 64'(e_rdata));
            check({e_tag, " rsp_ok"}, 64'(rsp_ok), 64'(e_ok));
        end
    endtask

    task automatic tick(input logic [N-1:0] v, input logic [2*N-1:0] ops,
                        input logic [AW*N-1:0] ad, input logic [DW*N-1:0] wd);
        int g;
        logic [1:0]    op;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit            link;
        @(negedge clk);
        check_rsp();
        req_valid = v; req_op = ops; req_addr = ad; req_wdata = wd;
        #1;
        g = -1;
        for (int i = N - 1; i >= 0; i--) if (v[i]) g = i;
        check("R1 grant", 64'(grant), (g < 0) ? 64'(0) : (64'(1) << g));
        e_valid = '0;
        if (g >= 0) begin
            op = ops[2*g +: 2];
            a  = ad[AW*g +: AW];
            d  = wd[DW*g +: DW];
            e_valid = N'(1) << g;
            e_rdata = m_mem[a];
            link = m_rv[g] && (m_ra[g] == a);
            e_ok = 1'b1;
            case (op)
                2'd0: e_tag = "R3";
                2'd1: begin
                    e_tag = "R7";
                    m_mem[a] = d;
                    for (int i = 0; i < N; i++) if (m_rv[i] && m_ra[i] == a) m_rv[i] = 0;
                end
                2'd2: begin
                    e_tag = "R4";
                    m_rv[g] = 1;
                    m_ra[g] = a;
                end
                default: begin
                    e_tag = link ? "R5" : "R6";
                    e_ok  = link;
                    if (link) begin
                        m_mem[a] = d;
                        for (int i = 0; i < N; i++) if (m_rv[i] && m_ra[i] == a) m_rv[i] = 0;
                    end
                    m_rv[g] = 0;
                end
            endcase
        end
    endtask

    task automatic one(input int ag, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        logic [N-1:0]    v  = '0;
        logic [2*N-1:0]  o  = '0;
        logic [AW*N-1:0] ad = '0;
        logic [DW*N-1:0] wd = '0;
        v[ag] = 1'b1;
        o[2*ag +: 2] = op;
        ad[AW*ag +: AW] = a;
        wd[DW*ag +: DW] = d;
        tick(v, o, ad, wd);
    endtask

    task automatic idle();
        tick('0, '0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R9 rsp_valid after reset", 64'(rsp_valid), 64'(0));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0]    v;
        logic [2*N-1:0]  o;
        logic [AW*N-1:0] ad;
        logic [DW*N-1:0] wd;
        model_clear();
        do_reset();
        // R3 plain write and read back
        one(0, 2'd1, 4'd9, 32'h1234_5678);
        one(1, 2'd0, 4'd9, 32'h0);
        // R4 + R5: link then successful conditional store
        one(1, 2'd2, 4'd3, 32'h0);
        one(1, 2'd3, 4'd3, 32'h0000_00AA);
        one(0, 2'd0, 4'd3, 32'h0);
        // R7: another agent's write breaks the link
        one(2, 2'd2, 4'd5, 32'h0);
        one(0, 2'd1, 4'd5, 32'h0000_0055);
        one(2, 2'd3, 4'd5, 32'hDEAD_BEEF);
        one(2, 2'd0, 4'd5, 32'h0);
        // R10: two conditional stores to one address in the same cycle
        one(0, 2'd2, 4'd7, 32'h0);
        one(3, 2'd2, 4'd7, 32'h0);
        o = '0; o[1:0] = 2'd3; o[7:6] = 2'd3;
        ad = '0; ad[3:0] = 4'd7; ad[15:12] = 4'd7;
        wd = '0; wd[31:0] = 32'h0000_0A0A; wd[127:96] = 32'h0000_3B3B;
        tick(4'b1001, o, ad, wd);
        one(3, 2'd3, 4'd7, 32'h0000_3B3B);
        one(1, 2'd0, 4'd7, 32'h0);
        // R4: a new link replaces the old one
        one(1, 2'd2, 4'd2, 32'h0);
        one(1, 2'd2, 4'd4, 32'h0);
        one(1, 2'd3, 4'd2, 32'h0000_0022);
        one(1, 2'd3, 4'd4, 32'h0000_0044);
        // R6 no link, R8 link consumed by store
        one(2, 2'd3, 4'd6, 32'h0000_0066);
        one(2, 2'd2, 4'd6, 32'h0);
        one(2, 2'd3, 4'd6, 32'h0000_0067);
        one(2, 2'd3, 4'd6, 32'h0000_0068);
        one(0, 2'd0, 4'd6, 32'h0);
        // R9: reset drops links and clears memory
        one(0, 2'd2, 4'd1, 32'h0);
        idle();
        do_reset();
        one(0, 2'd3, 4'd1, 32'h0000_0011);
        one(0, 2'd0, 4'd9, 32'h0);
        // random contention on four addresses
        for (int k = 0; k < 3000; k++) begin
            v = N'($urandom);
            for (int i = 0; i < N; i++) begin
                o[2*i +: 2]    = 2'($urandom);
                ad[AW*i +: AW] = AW'($urandom % 4);
                wd[DW*i +: DW] = $urandom;
            end
            tick(v, o, ad, wd);
        end
        idle();
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule